// File: doc/BRIEF.md
# Frame-Synchronous Shadow Register Bank

This block holds the configuration fields of a display controller that has several overlay windows. Each field has two copies. Software writes the shadow copy. The display pipeline sees only the active copy. Shadow values move to the active copies only on a vertical-sync pulse, and only after software has armed a commit. This means a set of changes that spans several registers never reaches the pipeline half-applied in the middle of a frame.

The fields are grouped by window, and each window has a hold (protect) bit. A window whose hold bit is set keeps its whole group out of the copy, even when a commit is armed. Software can therefore prepare several registers for one window over any number of frames. When it clears the hold bit and arms a commit again, the whole group is released at once. A single control word carries the commit request, a software reset and the hold bits. Bit 0 of a window's first field is that window's enable, and it takes effect only at a sync pulse.

Top module: `shadow_bank`

## Requirements
- R1: After `rst_ni` is released, every shadow field, every active field, the commit request and all hold bits read 0, and `win_en_o` and `active_o` are 0.
- R2: A write to field address `1 + w*FIELDS + f` (FIELDS = 4 by default) updates only the shadow copy on the next edge. With `rd_active_i` = 0 that address reads the shadow value, and `active_o` does not change.
- R3: With `rd_active_i` = 1, a field address reads the active copy instead of the shadow copy.
- R4: When `vsync_i` is high and the commit request is set, every window whose hold bit is clear has all of its active fields loaded from its shadow fields on that edge. `win_en_o[w]` follows bit 0 of window w's active field 0, so clearing an enable takes effect only at that sync.
- R5: A `vsync_i` pulse while the commit request is clear copies nothing.
- R6: Control word (address 0) bit 8+w is window w's hold bit, applied immediately on write. While it is set, a committing sync leaves window w's active fields unchanged, and the other windows still commit.
- R7: Shadow values held back by a hold bit are applied at the first committing sync after the hold bit is cleared and a new commit is requested.
- R8: Writing 1 to control bit 0 sets the commit request, which reads back as 1 until the next `vsync_i` and then clears, whether or not any window was held. Writing 0 to bit 0 does not cancel a pending request.
- R9: Writing 1 to control bit 1 (software reset, reads 0) returns all shadow fields, active fields, hold bits and the request to 0 on that edge. It overrides a sync pulse in the same cycle.
- R10: When a field write and a committing `vsync_i` fall in the same cycle, the shadow copy takes the new data and the active copy takes the shadow value from before that write.
- R11: When a control write and `vsync_i` fall in the same cycle, that sync uses the request and hold bits from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vsync_i | input | 1 | One-cycle vertical-sync pulse |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W (4) | Word address: 0 control, then fields by window |
| wr_data_i | input | DATA_W (32) | Write data |
| rd_active_i | input | 1 | Select the active copy for reads |
| rd_data_o | output | DATA_W (32) | Combinational read data for `addr_i` |
| active_o | output | NUM_WIN*FIELDS*DATA_W (256) | All active fields, window 0 field 0 in the LSBs |
| win_en_o | output | NUM_WIN (2) | Per-window enable taken from the active copy |

## Verification
The copy is tried under several conditions:
- Sync without a request. This separates a design that copies on every sync from one that waits for the request.
- Sync with a request and no hold bits. This shows that every window is copied.
- Sync with one window held. This shows that the hold is per window and that the request still clears.
- The release of a held window on a later committing sync.

Same-cycle collisions are also driven:
- A field write with a sync.
- A control write with a sync.
- A software reset with a sync.

Each collision tells apart designs that apply the old shadow value or the new one, and the old control bits or the new ones.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int unsigned CTRL_REQ_BIT  = 0;
  localparam int unsigned CTRL_SRST_BIT = 1;
  localparam int unsigned CTRL_PROT_LSB = 8;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_bank_pkg::*;
#(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vsync_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               soft_rst_o,
  output logic [NUM_WIN-1:0] commit_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic               req_q;
  logic [NUM_WIN-1:0] prot_q;

  assign soft_rst_o = wr_en_i & wr_data_i[CTRL_SRST_BIT];

  // sync uses pre-write request and hold bits
  always_comb begin
    for (int w = 0; w < NUM_WIN; w++) commit_o[w] = vsync_i & req_q & ~prot_q[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      prot_q <= '0;
    end else if (soft_rst_o) begin
      req_q  <= 1'b0;
      prot_q <= '0;
    end else begin
      if (wr_en_i && wr_data_i[CTRL_REQ_BIT]) req_q <= 1'b1;
      else if (vsync_i)                        req_q <= 1'b0;
      if (wr_en_i) prot_q <= wr_data_i[CTRL_PROT_LSB +: NUM_WIN];
    end
  end

  always_comb begin
    rd_data_o                          = '0;
    rd_data_o[CTRL_REQ_BIT]            = req_q;
    rd_data_o[CTRL_PROT_LSB +: NUM_WIN] = prot_q;
  end

  // R8
  req_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && !wr_en_i) |=> !req_q);

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !vsync_i && !soft_rst_o) |=> req_q);

  // R9
  srst_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (!req_q && prot_q == '0));
endmodule

// File: rtl/shadow_win.sv
module shadow_win
  import shadow_bank_pkg::*;
#(
  parameter int unsigned FIELDS = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned FLD_W = idx_w(FIELDS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     soft_rst_i,
  input  logic                     wr_en_i,
  input  logic [FLD_W-1:0]         wr_field_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     commit_i,
  input  logic [FLD_W-1:0]         rd_field_i,
  input  logic                     rd_active_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic [FIELDS*DATA_W-1:0] active_o
);
  logic [FIELDS-1:0][DATA_W-1:0] shadow_q;
  logic [FIELDS-1:0][DATA_W-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else if (soft_rst_i) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en_i) shadow_q[wr_field_i] <= wr_data_i;
      if (commit_i) active_q <= shadow_q;  // old shadow on collision
    end
  end

  assign rd_data_o = rd_active_i ? active_q[rd_field_i] : shadow_q[rd_field_i];
  assign active_o  = active_q;

  // R2
  shadow_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !soft_rst_i) |=> shadow_q[$past(wr_field_i)] == $past(wr_data_i));

  // R2
  active_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !soft_rst_i) |=> $stable(active_q));

  // R4
  commit_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !soft_rst_i) |=> active_q == $past(shadow_q));

  // R9
  srst_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (active_q == '0 && shadow_q == '0));
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned FIELDS  = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned ADDR_W = $clog2(NUM_WIN*FIELDS + 1),
  localparam int unsigned WIN_DW = FIELDS*DATA_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vsync_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic                      rd_active_i,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic [NUM_WIN*WIN_DW-1:0] active_o,
  output logic [NUM_WIN-1:0]        win_en_o
);
  localparam int unsigned WIN_W = idx_w(NUM_WIN);
  localparam int unsigned FLD_W = idx_w(FIELDS);

  logic [ADDR_W-1:0] idx;
  logic [WIN_W-1:0]  win_sel;
  logic [FLD_W-1:0]  fld_sel;
  logic              fld_hit, ctrl_hit;
  logic              soft_rst;
  logic [NUM_WIN-1:0] commit;
  logic [DATA_W-1:0] ctrl_rd;
  logic [DATA_W-1:0] win_rd [NUM_WIN];

  always_comb begin
    idx      = addr_i - ADDR_W'(1);
    win_sel  = WIN_W'(idx / ADDR_W'(FIELDS));
    fld_sel  = FLD_W'(idx % ADDR_W'(FIELDS));
    ctrl_hit = (addr_i == '0);
    fld_hit  = !ctrl_hit && (addr_i <= ADDR_W'(NUM_WIN*FIELDS));
  end

  shadow_ctrl #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vsync_i    (vsync_i),
    .wr_en_i    (wr_en_i && ctrl_hit),
    .wr_data_i  (wr_data_i),
    .soft_rst_o (soft_rst),
    .commit_o   (commit),
    .rd_data_o  (ctrl_rd)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    shadow_win #(.FIELDS(FIELDS), .DATA_W(DATA_W)) u_win (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .soft_rst_i  (soft_rst),
      .wr_en_i     (wr_en_i && fld_hit && win_sel == WIN_W'(w)),
      .wr_field_i  (fld_sel),
      .wr_data_i   (wr_data_i),
      .commit_i    (commit[w]),
      .rd_field_i  (fld_sel),
      .rd_active_i (rd_active_i),
      .rd_data_o   (win_rd[w]),
      .active_o    (active_o[w*WIN_DW +: WIN_DW])
    );
    assign win_en_o[w] = active_o[w*WIN_DW];

    // R6
    held_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_rd[CTRL_PROT_LSB + w] && !soft_rst) |=> $stable(active_o[w*WIN_DW +: WIN_DW]));
  end

  always_comb begin
    rd_data_o = '0;
    if (ctrl_hit)     rd_data_o = ctrl_rd;
    else if (fld_hit) rd_data_o = win_rd[win_sel];
  end

  // R5
  no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && !ctrl_rd[CTRL_REQ_BIT] && !soft_rst) |=> $stable(active_o));
endmodule

// File: tb/shadow_bank_tb.sv
module shadow_bank_tb;
  localparam int AW = 4;
  localparam int DW = 32;

  typedef struct packed {
    logic [1:0]    op;    // 0 write, 1 vsync, 2 read-compare
    logic [AW-1:0] addr;
    logic          sel;
    logic [DW-1:0] data;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd1, 1'b0, 32'hA5A5_0001, 4'd2},
    '{2'd0, 4'd6, 1'b0, 32'h1234_5678, 4'd2},
    '{2'd2, 4'd1, 1'b0, 32'hA5A5_0001, 4'd2},  // R2 shadow read
    '{2'd2, 4'd1, 1'b1, 32'h0000_0000, 4'd3},  // R3 active untouched
    '{2'd1, 4'd0, 1'b0, 32'h0,         4'd5},
    '{2'd2, 4'd1, 1'b1, 32'h0000_0000, 4'd5},  // R5 no request, no copy
    '{2'd0, 4'd0, 1'b0, 32'h0000_0001, 4'd8},
    '{2'd2, 4'd0, 1'b0, 32'h0000_0001, 4'd8},  // R8 pending reads 1
    '{2'd1, 4'd0, 1'b0, 32'h0,         4'd4},
    '{2'd2, 4'd1, 1'b1, 32'hA5A5_0001, 4'd4},  // R4 win0 copied
    '{2'd2, 4'd6, 1'b1, 32'h1234_5678, 4'd4},  // R4 win1 copied
    '{2'd2, 4'd0, 1'b0, 32'h0000_0000, 4'd8},  // R8 self-clear
    '{2'd0, 4'd0, 1'b0, 32'h0000_0201, 4'd6},
    '{2'd0, 4'd5, 1'b0, 32'h0000_0003, 4'd6},
    '{2'd0, 4'd1, 1'b0, 32'h0000_0000, 4'd4},
    '{2'd1, 4'd0, 1'b0, 32'h0,         4'd6},
    '{2'd2, 4'd1, 1'b1, 32'h0000_0000, 4'd4},  // R4 disable applied at sync
    '{2'd2, 4'd5, 1'b1, 32'h0000_0000, 4'd6},  // R6 held window unchanged
    '{2'd2, 4'd0, 1'b0, 32'h0000_0200, 4'd8},  // R8 cleared even with hold
    '{2'd0, 4'd0, 1'b0, 32'h0000_0001, 4'd7},
    '{2'd1, 4'd0, 1'b0, 32'h0,         4'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0, wr_en = 1'b0, rd_act = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [255:0]  active;
  logic [1:0]    win_en;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  shadow_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_active_i(rd_act),
    .rd_data_o(rdata), .active_o(active), .win_en_o(win_en)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus: optional write, optional sync
  task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic vs);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; vsync = vs;
    @(negedge clk);
    wr_en = 1'b0; vsync = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic s, input logic [DW-1:0] exp);
    @(negedge clk);
    addr = a; rd_act = s;
    #1 chk(tag, rdata, exp);
    rd_act = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nchk++; nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 ctrl", 4'd0, 1'b0, 32'h0);
    rd("R1 shadow", 4'd3, 1'b0, 32'h0);
    rd("R1 active", 4'd8, 1'b1, 32'h0);
    chk("R1 win_en", {30'b0, win_en}, 32'h0);
    chk("R1 active_o", active[31:0] | active[255:224], 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: cyc(1'b1, VEC[i].addr, VEC[i].data, 1'b0);
        2'd1: cyc(1'b0, 4'd0, 32'h0, 1'b1);
        default: rd($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].sel, VEC[i].data);
      endcase
    end

    // R7 released window applied
    rd("R7 win1 f0", 4'd5, 1'b1, 32'h3);
    // R4 enable follows active field 0 bit 0
    chk("R4 win_en", {30'b0, win_en}, 32'h2);

    // R10 field write collides with committing sync
    cyc(1'b1, 4'd0, 32'h1, 1'b0);
    cyc(1'b1, 4'd2, 32'h0000_BEEF, 1'b1);
    rd("R10 active old", 4'd2, 1'b1, 32'h0);
    rd("R10 shadow new", 4'd2, 1'b0, 32'h0000_BEEF);

    // R11 control write collides with sync: old request (0) used
    cyc(1'b1, 4'd3, 32'h77, 1'b0);
    cyc(1'b1, 4'd0, 32'h1, 1'b1);
    rd("R11 no copy", 4'd3, 1'b1, 32'h0);
    rd("R11 req set", 4'd0, 1'b0, 32'h1);
    // R8 writing 0 does not cancel
    cyc(1'b1, 4'd0, 32'h0, 1'b0);
    rd("R8 no cancel", 4'd0, 1'b0, 32'h1);
    cyc(1'b0, 4'd0, 32'h0, 1'b1);
    rd("R11 later copy", 4'd3, 1'b1, 32'h77);
    rd("R10 later copy", 4'd2, 1'b1, 32'h0000_BEEF);

    // R9 software reset overrides same-cycle committing sync
    cyc(1'b1, 4'd7, 32'h55, 1'b0);
    cyc(1'b1, 4'd0, 32'h0000_0101, 1'b0);
    cyc(1'b1, 4'd0, 32'h0000_0002, 1'b1);
    rd("R9 ctrl", 4'd0, 1'b0, 32'h0);
    rd("R9 shadow", 4'd7, 1'b0, 32'h0);
    rd("R9 active", 4'd3, 1'b1, 32'h0);
    rd("R9 active w1", 4'd5, 1'b1, 32'h0);
    chk("R9 win_en", {30'b0, win_en}, 32'h0);

    finish_run();
  end
endmodule